// File: doc/BRIEF.md
# USB controller interrupt wrapper

This block sits between a USB on-the-go controller core and a processor register bus. It gathers per-endpoint transmit and receive events and the core's USB event flags into two latched source banks. Each bank has a mask and a masked view. Software can force or acknowledge source bits through write-one aliases, and it can set or clear mask bits the same way. A single level interrupt line to the processor is driven from the masked banks. Once the line has asserted it stays latched, and it cannot assert again until software writes the end-of-interrupt location.

There are three more registers. A read-only identification word confirms that the block is clocked and present. A control word carries a self-clearing soft-reset command. A status word mirrors the core's request to drive VBUS. All registers are 32 bits wide at word offsets. Writes take effect on the clock edge where `cpu_wr` is high. Reads are combinational from `cpu_addr` and have no side effects.

Top module: `usb_irq_wrapper`

## Requirements
- R1: After synchronous reset every register reads zero except the identification word at 0x00, and `irq_out` is low.
- R2: Offset 0x00 always reads the nonzero parameter `REV_ID`, and writes to it have no effect.
- R3: Endpoint source word at 0x20: `ep_tx_evt[i]` latches bit i (0..15) and `ep_rx_evt[j]` latches bit 16+j (j = 1..15); `ep_rx_evt[0]` is ignored and bit 16 always reads zero, even after a forcing write.
- R4: Core source word at 0x40: `core_evt[k]` latches bit 16+k (k = 0..8, bit 24 being the VBUS-drive change flag); bits outside 16..24 read zero and writes to them are dropped.
- R5: Writing ones to 0x24/0x44 sets, and to 0x28/0x48 clears, the matching source bits; zero bits leave bits unchanged, the aliases read zero, and direct writes to 0x20/0x40 are ignored.
- R6: A hardware event arriving in the same cycle as a clear of its bit leaves the bit set.
- R7: Mask words at 0x2C/0x4C read back the mask; ones written to 0x30/0x50 set and to 0x34/0x54 clear mask bits, zero bits leave them unchanged.
- R8: Offsets 0x38/0x58 read the bitwise AND of each bank's source and mask.
- R9: When the line is low and any masked bit is set, `irq_out` rises on the clock edge after the one that made the masked bit nonzero.
- R10: Once high, `irq_out` stays high, whatever happens to sources and masks, until a write to 0x60; the written data is ignored.
- R11: A write to 0x60 drops `irq_out` at that edge; if a masked bit is still pending it rises again on the following edge.
- R12: Writing 1 to bit 0 of 0x04 clears both banks, both masks and `irq_out`; 0x04 reads zero, and writing 0 there changes nothing.
- R13: Bit 0 of 0x08 equals `vbus_drive_req`; other status bits and the reserved offsets 0x10 and 0x5C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 8 | Byte offset of the addressed word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` |
| ep_tx_evt | input | 16 | Transmit endpoint event pulses, endpoints 0..15 |
| ep_rx_evt | input | 16 | Receive endpoint event pulses; bit 0 unused |
| core_evt | input | 9 | Core USB event pulses; bit 8 is the VBUS-drive change |
| vbus_drive_req | input | 1 | Core request to drive VBUS |
| irq_out | output | 1 | Level interrupt to the processor |

## Verification
The bench builds the block with its default parameters: sixteen transmit and sixteen receive endpoint positions and a nine-flag core field at bit 16. These values fill the endpoint word completely. The missing receive endpoint zero then falls exactly on bit 16, and the VBUS-drive flag lands on bit 24. With them the bench can check the hole at bit 16, the top core flag, forcing through aliases, and the EOI re-arm and re-assert at the real bit positions software uses.

// File: rtl/usb_irq_pkg.sv
// Package: register offsets and the per-bank write-strobe bundle shared by
// the interrupt wrapper and its banks. Assumes 32-bit words at byte offsets.
package usb_irq_pkg;

    localparam logic [7:0] OFS_REV       = 8'h00;
    localparam logic [7:0] OFS_CTRL      = 8'h04;
    localparam logic [7:0] OFS_STAT      = 8'h08;
    localparam logic [7:0] OFS_EP_SRC    = 8'h20;
    localparam logic [7:0] OFS_EP_SET    = 8'h24;
    localparam logic [7:0] OFS_EP_CLR    = 8'h28;
    localparam logic [7:0] OFS_EP_MSK    = 8'h2C;
    localparam logic [7:0] OFS_EP_MSET   = 8'h30;
    localparam logic [7:0] OFS_EP_MCLR   = 8'h34;
    localparam logic [7:0] OFS_EP_MASKED = 8'h38;
    localparam logic [7:0] OFS_CO_SRC    = 8'h40;
    localparam logic [7:0] OFS_CO_SET    = 8'h44;
    localparam logic [7:0] OFS_CO_CLR    = 8'h48;
    localparam logic [7:0] OFS_CO_MSK    = 8'h4C;
    localparam logic [7:0] OFS_CO_MSET   = 8'h50;
    localparam logic [7:0] OFS_CO_MCLR   = 8'h54;
    localparam logic [7:0] OFS_CO_MASKED = 8'h58;
    localparam logic [7:0] OFS_EOI       = 8'h60;

    // One-cycle write strobes aimed at a single bank
    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
    } bank_wr_t;

endpackage

// File: rtl/usb_irq_bank.sv
// Module: one interrupt source bank. It holds a sticky source vector and a mask,
// and it presents their AND. Hardware events OR into the source; write-one
// aliases set or clear the source or the mask. An event beats a clear in the
// same cycle. Bits outside VALID never set.
// Assumes: strobes are single-cycle and at most one is active per cycle.
module usb_irq_bank
    import usb_irq_pkg::*;
#(
    parameter int          W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] hw_evt,
    input  bank_wr_t     wr,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] src,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);

    logic [W-1:0] src_q, mask_q;
    logic [W-1:0] set_v, clr_v, mset_v, mclr_v;

    // Expand the strobes into per-bit set and clear vectors
    always_comb begin
        set_v  = wr.src_set ? wbits : '0;
        clr_v  = wr.src_clr ? wbits : '0;
        mset_v = wr.msk_set ? wbits : '0;
        mclr_v = wr.msk_clr ? wbits : '0;
    end

    // Source and mask state; the event term is ORed after the clear so it wins
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q  <= ((src_q & ~clr_v) | set_v | hw_evt) & VALID;
            mask_q <= ((mask_q & ~mclr_v) | mset_v) & VALID;
        end
    end

    assign src    = src_q;
    assign mask   = mask_q;
    assign masked = src_q & mask_q;

    // R3 R4 R6: every valid event seen last cycle is held now
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_clr |=> (($past(hw_evt) & VALID & ~src) == '0));

    // R5: forced bits are present after the set alias
    a_r5_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.src_set && !soft_clr) |=> (($past(wbits) & VALID & ~src) == '0));

    // R5: cleared bits are gone unless an event hit them
    a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.src_clr && !soft_clr) |=> ((src & $past(wbits & ~hw_evt)) == '0));

    // R7: mask clear alias removes the written bits
    a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.msk_clr && !soft_clr) |=> ((mask & $past(wbits)) == '0));

    // R12: soft reset empties the bank
    a_r12_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (src == '0 && mask == '0));

endmodule

// File: rtl/usb_irq_line.sv
// Module: latched level interrupt line. It rises when anything is pending and
// stays high until an end-of-interrupt write, which re-arms it. If anything is
// still pending after that write, the line rises again on the next edge.
// Assumes: pend comes from registered state (the banks' masked outputs).
module usb_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic eoi,
    input  logic pend,
    output logic irq
);

    logic irq_q;

    // Latch the line on pending, release only on EOI or reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr || eoi) irq_q <= 1'b0;
        else                           irq_q <= irq_q | pend;
    end

    assign irq = irq_q;

    // R9: armed line with a pending bit asserts next edge
    a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && pend && !eoi && !soft_clr) |=> irq_q);

    // R10: asserted line holds until EOI
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !eoi && !soft_clr) |=> irq_q);

    // R11: EOI write lowers the line
    a_r11_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq_q);

endmodule

// File: rtl/usb_irq_wrapper.sv
// Module: top of the USB interrupt wrapper. It decodes the register bus,
// places endpoint and core events into their banks, forms the read mux, and
// drives the latched interrupt line.
// Assumes: 32-bit data, one write per cycle, reads without side effects,
// 2*NUM_EP <= 32 and CORE_LSB+CORE_W <= 32.
module usb_irq_wrapper
    import usb_irq_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          NUM_EP   = 16,
    parameter int          CORE_W   = 9,
    parameter int          CORE_LSB = 16,
    parameter logic [31:0] REV_ID   = 32'h4D31_0203
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [31:0]         cpu_wdata,
    output logic [31:0]         cpu_rdata,
    input  logic [NUM_EP-1:0]   ep_tx_evt,
    input  logic [NUM_EP-1:0]   ep_rx_evt,
    input  logic [CORE_W-1:0]   core_evt,
    input  logic                vbus_drive_req,
    output logic                irq_out
);

    localparam int              DATA_W   = 32;
    localparam int              EP_W     = 2 * NUM_EP;
    localparam logic [EP_W-1:0] EP_VALID = ~(EP_W'(1) << NUM_EP);

    logic [EP_W-1:0]   ep_src, ep_msk, ep_masked;
    logic [CORE_W-1:0] co_src, co_msk, co_masked;
    bank_wr_t          ep_wr, co_wr;
    logic              soft_clr, eoi_wr, pend;

    // Decode write strobes for each offset
    always_comb begin
        ep_wr.src_set = cpu_wr && (cpu_addr == ADDR_W'(OFS_EP_SET));
        ep_wr.src_clr = cpu_wr && (cpu_addr == ADDR_W'(OFS_EP_CLR));
        ep_wr.msk_set = cpu_wr && (cpu_addr == ADDR_W'(OFS_EP_MSET));
        ep_wr.msk_clr = cpu_wr && (cpu_addr == ADDR_W'(OFS_EP_MCLR));
        co_wr.src_set = cpu_wr && (cpu_addr == ADDR_W'(OFS_CO_SET));
        co_wr.src_clr = cpu_wr && (cpu_addr == ADDR_W'(OFS_CO_CLR));
        co_wr.msk_set = cpu_wr && (cpu_addr == ADDR_W'(OFS_CO_MSET));
        co_wr.msk_clr = cpu_wr && (cpu_addr == ADDR_W'(OFS_CO_MCLR));
        soft_clr      = cpu_wr && (cpu_addr == ADDR_W'(OFS_CTRL)) && cpu_wdata[0];
        eoi_wr        = cpu_wr && (cpu_addr == ADDR_W'(OFS_EOI));
    end

    usb_irq_bank #(.W(EP_W), .VALID(EP_VALID)) u_ep_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .hw_evt   ({ep_rx_evt, ep_tx_evt}),
        .wr       (ep_wr),
        .wbits    (cpu_wdata[EP_W-1:0]),
        .src      (ep_src),
        .mask     (ep_msk),
        .masked   (ep_masked)
    );

    usb_irq_bank #(.W(CORE_W), .VALID({CORE_W{1'b1}})) u_core_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .hw_evt   (core_evt),
        .wr       (co_wr),
        .wbits    (cpu_wdata[CORE_LSB +: CORE_W]),
        .src      (co_src),
        .mask     (co_msk),
        .masked   (co_masked)
    );

    // Anything pending in either masked view
    assign pend = (|ep_masked) | (|co_masked);

    usb_irq_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .eoi      (eoi_wr),
        .pend     (pend),
        .irq      (irq_out)
    );

    // Read mux; aliases, control and reserved offsets return zero
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            ADDR_W'(OFS_REV):       cpu_rdata = REV_ID;
            ADDR_W'(OFS_STAT):      cpu_rdata = {{(DATA_W-1){1'b0}}, vbus_drive_req};
            ADDR_W'(OFS_EP_SRC):    cpu_rdata = DATA_W'(ep_src);
            ADDR_W'(OFS_EP_MSK):    cpu_rdata = DATA_W'(ep_msk);
            ADDR_W'(OFS_EP_MASKED): cpu_rdata = DATA_W'(ep_masked);
            ADDR_W'(OFS_CO_SRC):    cpu_rdata = DATA_W'(co_src) << CORE_LSB;
            ADDR_W'(OFS_CO_MSK):    cpu_rdata = DATA_W'(co_msk) << CORE_LSB;
            ADDR_W'(OFS_CO_MASKED): cpu_rdata = DATA_W'(co_masked) << CORE_LSB;
            default:                cpu_rdata = '0;
        endcase
    end

    // R12: the line is low the cycle after a soft reset
    a_r12_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !irq_out);

endmodule

// File: tb/usb_irq_wrapper_test.sv
`timescale 1ns/1ps
module usb_irq_wrapper_test;

    localparam logic [31:0] REV = 32'h4D31_0203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [15:0] ep_tx_evt = '0;
    logic [15:0] ep_rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus_drive_req = 1'b0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit mon_on = 0;

    // reference model state
    logic [31:0] m_ep = '0, m_epm = '0, m_co = '0, m_com = '0;
    logic        m_irq = 1'b0;

    always #4 clk = ~clk;

    usb_irq_wrapper #(.REV_ID(REV)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ep_tx_evt(ep_tx_evt),
        .ep_rx_evt(ep_rx_evt), .core_evt(core_evt),
        .vbus_drive_req(vbus_drive_req), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic        pending, is_soft, is_eoi;
        logic [31:0] wd, hw_ep, hw_co;
        pending = ((m_ep & m_epm) != 0) || ((m_co & m_com) != 0);
        wd      = cpu_wdata;
        is_soft = cpu_wr && cpu_addr == 8'h04 && wd[0];
        is_eoi  = cpu_wr && cpu_addr == 8'h60;
        hw_ep   = {ep_rx_evt, ep_tx_evt};
        hw_co   = {7'd0, core_evt, 16'd0};
        if (!rst_n || is_soft) begin
            m_ep = 0; m_epm = 0; m_co = 0; m_com = 0; m_irq = 0;
        end else begin
            if (cpu_wr) begin
                case (cpu_addr)
                    8'h24: m_ep  = m_ep | wd;
                    8'h28: m_ep  = m_ep & ~wd;
                    8'h30: m_epm = m_epm | wd;
                    8'h34: m_epm = m_epm & ~wd;
                    8'h44: m_co  = m_co | wd;
                    8'h48: m_co  = m_co & ~wd;
                    8'h50: m_com = m_com | wd;
                    8'h54: m_com = m_com & ~wd;
                    default: ;
                endcase
            end
            m_ep  = (m_ep | hw_ep) & 32'hFFFE_FFFF;
            m_epm = m_epm & 32'hFFFE_FFFF;
            m_co  = (m_co | hw_co) & 32'h01FF_0000;
            m_com = m_com & 32'h01FF_0000;
            m_irq = is_eoi ? 1'b0 : (m_irq | pending);
        end
    end

    // line compared against the model every cycle (R9 R10 R11)
    always @(negedge clk) if (mon_on) chk("R10 irq line vs model", 32'(irq_out), 32'(m_irq));

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(req, cpu_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        // R1 reset state
        chk("R1 irq after reset", 32'(irq_out), 32'd0);
        for (int a = 4; a < 8'h64; a += 4) rd("R1 reset read", 8'(a), 32'd0);
        // R2 identification
        rd("R2 rev", 8'h00, REV);
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 rev after write", 8'h00, REV);
        // R13 status and reserved
        vbus_drive_req = 1'b1;
        rd("R13 status on", 8'h08, 32'h1);
        wr(8'h10, 32'hFFFF_FFFF);
        rd("R13 reserved 10", 8'h10, 32'h0);
        rd("R13 reserved 5C", 8'h5C, 32'h0);
        vbus_drive_req = 1'b0;
        rd("R13 status off", 8'h08, 32'h0);
        // R3 endpoint layout
        @(negedge clk); ep_tx_evt = 16'h8001; ep_rx_evt = 16'h0003;
        @(negedge clk); ep_tx_evt = '0; ep_rx_evt = '0;
        rd("R3 ep layout", 8'h20, 32'h0002_8001);
        // R5 aliases
        wr(8'h24, 32'h0001_0100);
        rd("R5 set alias (bit16 stays 0 R3)", 8'h20, 32'h0002_8101);
        rd("R5 set alias reads zero", 8'h24, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd("R5 direct src write ignored", 8'h20, 32'h0002_8101);
        wr(8'h28, 32'h0000_0001);
        rd("R5 clear alias", 8'h20, 32'h0002_8100);
        rd("R5 clear alias reads zero", 8'h28, 32'h0);
        // R6 event vs clear in one cycle
        @(negedge clk);
        ep_tx_evt = 16'h0100; cpu_wr = 1'b1; cpu_addr = 8'h28; cpu_wdata = 32'h0002_0100;
        @(negedge clk);
        ep_tx_evt = '0; cpu_wr = 1'b0; cpu_wdata = '0;
        rd("R6 event beats clear", 8'h20, 32'h0000_8100);
        // R7 R8 R9 mask and line
        wr(8'h30, 32'h0000_0100);
        chk("R9 line not yet", 32'(irq_out), 32'd0);
        @(negedge clk);
        chk("R9 line rises", 32'(irq_out), 32'd1);
        rd("R7 ep mask", 8'h2C, 32'h0000_0100);
        rd("R8 ep masked", 8'h38, 32'h0000_0100);
        // R10 hold
        wr(8'h28, 32'hFFFF_FFFF);
        rd("R10 src cleared", 8'h20, 32'h0);
        chk("R10 line holds", 32'(irq_out), 32'd1);
        @(negedge clk); core_evt = 9'h001;
        @(negedge clk); core_evt = '0;
        chk("R10 line still high", 32'(irq_out), 32'd1);
        // R11 EOI with nothing pending
        wr(8'h60, 32'h0000_1234);
        chk("R11 EOI drops line", 32'(irq_out), 32'd0);
        repeat (2) @(negedge clk);
        chk("R11 stays low", 32'(irq_out), 32'd0);
        // R4 core bank
        wr(8'h44, 32'h0100_0000);
        rd("R4 core src", 8'h40, 32'h0101_0000);
        wr(8'h44, 32'hFE00_FFFF);
        rd("R4 outside field dropped", 8'h40, 32'h0101_0000);
        wr(8'h50, 32'h0100_0000);
        rd("R7 core mask", 8'h4C, 32'h0100_0000);
        rd("R8 core masked", 8'h58, 32'h0100_0000);
        chk("R9 core raises line", 32'(irq_out), 32'd1);
        // R11 re-assert while pending
        wr(8'h60, 32'h0);
        chk("R11 drop on EOI", 32'(irq_out), 32'd0);
        @(negedge clk);
        chk("R11 re-assert", 32'(irq_out), 32'd1);
        wr(8'h54, 32'h0100_0000);
        rd("R7 core mask cleared", 8'h58, 32'h0);
        wr(8'h60, 32'h0);
        repeat (2) @(negedge clk);
        chk("R11 low after mask clear", 32'(irq_out), 32'd0);
        // R12 soft reset
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        rd("R12 zero write no effect", 8'h40, 32'h0101_0000);
        wr(8'h04, 32'h1);
        rd("R12 ctrl reads zero", 8'h04, 32'h0);
        rd("R12 core cleared", 8'h40, 32'h0);
        rd("R12 ep mask cleared", 8'h2C, 32'h0);
        chk("R12 line low", 32'(irq_out), 32'd0);
        repeat (3) @(negedge clk);
        mon_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule